// File: doc/BRIEF.md
# Byte-Lane Logic Execution Unit

This block is a combinational execution slice for a 32-bit scalar core. It covers two immediate logic operations that act on the upper half of a word, a per-byte merge of two operands, and a detector that reports whether any byte lane of two operands holds the same value. The two operands, a 16-bit immediate, a 4-bit lane mask and a 2-bit operation code enter together. The result word and the lane-hit flag are valid in the same cycle.

The core feeds the register operands and decoded fields in directly. It writes `result` back to its register file. The branch unit takes `lane_hit` to decide a byte-lane conditional branch. Some instruction forms use the destination as the first source. This changes only which register feeds `opd_a`, so the datapath is the same in both forms.

Top module: `bytelane_logic_unit`

## Requirements
- R1: With `op_sel` = 2'b00 (and-upper), `result` = `opd_a` AND (`imm` placed in bits 31:16, with ones in bits 15:0). The low half of `opd_a` therefore passes through unchanged.
- R2: With `op_sel` = 2'b01 (or-upper), `result` = `opd_a` OR (`imm` placed in bits 31:16, with zeros in bits 15:0). The low half of `opd_a` passes through unchanged.
- R3: With `op_sel` = 2'b10 (merge), byte lane i of `result` comes from `opd_b` when `lane_mask[i]` is 1 and from `opd_a` when it is 0. Lane 0 is bits 7:0 and lane 3 is bits 31:24.
- R4: `lane_hit` is 1 whenever at least one of the four byte lanes of `opd_a` equals the same lane of `opd_b`. This holds when exactly one lane matches, whichever lane that is.
- R5: `lane_hit` is 0 only when all four lanes differ.
- R6: With `op_sel` = 2'b11 (lane compare), `result` is zero.
- R7: `lane_hit` depends only on the operands and is the same under every `op_sel` value.
- R8: The unit is purely combinational. Both outputs follow the inputs in the same cycle, and a register stage placed after the unit captures them at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | 32 | First source operand (also destination in the two-operand form) |
| opd_b | input | 32 | Second source operand |
| imm | input | 16 | Immediate for the upper-half operations |
| lane_mask | input | 4 | Per-lane source select for merge |
| op_sel | input | 2 | Operation code: 00 and-upper, 01 or-upper, 10 merge, 11 compare |
| result | output | 32 | Operation result |
| lane_hit | output | 1 | At least one byte lane is equal in both operands |

## Verification
The result of a logic or merge operation and the lane-hit flag come out in the same cycle. The flag keeps working when the compare operation is not selected. To provoke this, the bench feeds and-upper, or-upper and merge vectors whose operands share zero, one or all byte lanes. At a single sample point it judges both outputs: the result against the word rule of the selected operation, and the flag against its own lane-equality model. A final pass holds one operand pair fixed and steps through all four operation codes, so the flag must stay constant while the result changes.

// File: rtl/blu_pkg.sv
package blu_pkg;

   typedef enum logic [1:0] {
      OP_ANDHI  = 2'b00,
      OP_ORHI   = 2'b01,
      OP_MERGE  = 2'b10,
      OP_LANEEQ = 2'b11
   } blu_op_e;

endpackage

// File: rtl/blu_upper_imm.sv
module blu_upper_imm #(
   parameter int  DATA_W  = 32,
   parameter bit  OR_MODE = 1'b0,
   localparam int IMM_W   = DATA_W / 2
) (
   input  logic [DATA_W-1:0] src,
   input  logic [IMM_W-1:0]  imm,
   output logic [DATA_W-1:0] res
);

   if (DATA_W % 2 != 0) begin : g_bad_width
      $error("blu_upper_imm: DATA_W must be even");
   end

   if (OR_MODE) begin : g_or
      assign res = src | {imm, {IMM_W{1'b0}}};

      // R2: every immediate bit set must appear in the upper half
      always_comb begin
         p_imm_bits_set_r2: assert ((res[DATA_W-1:IMM_W] & imm) == imm)
            else $error("or-upper lost an immediate bit");
      end
   end else begin : g_and
      assign res = src & {imm, {IMM_W{1'b1}}};

      // R1: upper half may only clear bits, never set them
      always_comb begin
         p_no_new_bits_r1: assert ((res[DATA_W-1:IMM_W] & ~src[DATA_W-1:IMM_W]) == '0)
            else $error("and-upper set a bit absent from the operand");
      end
   end

   // R1 R2: low half is the operand in both variants
   always_comb begin
      p_low_half_kept_r1: assert (res[IMM_W-1:0] == src[IMM_W-1:0])
         else $error("upper-half operation disturbed the low half");
   end

endmodule

// File: rtl/blu_lane_merge.sv
module blu_lane_merge #(
   parameter int  LANE_W = 8,
   parameter int  LANES  = 4,
   localparam int DATA_W = LANE_W * LANES
) (
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [LANES-1:0]  pick_b,
   output logic [DATA_W-1:0] merged
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign merged[i*LANE_W +: LANE_W] =
         pick_b[i] ? src_b[i*LANE_W +: LANE_W] : src_a[i*LANE_W +: LANE_W];

      // R3: each lane is a copy of one of the two sources
      always_comb begin
         p_lane_source_r3: assert (merged[i*LANE_W +: LANE_W] == src_a[i*LANE_W +: LANE_W] ||
                                   merged[i*LANE_W +: LANE_W] == src_b[i*LANE_W +: LANE_W])
            else $error("merge lane %0d matches neither source", i);
      end
   end

endmodule

// File: rtl/blu_lane_cmp.sv
module blu_lane_cmp #(
   parameter int  LANE_W = 8,
   parameter int  LANES  = 4,
   localparam int DATA_W = LANE_W * LANES
) (
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   output logic              hit
);

   logic [LANES-1:0] lane_eq;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_eq[i] = (src_a[i*LANE_W +: LANE_W] == src_b[i*LANE_W +: LANE_W]);
   end

   assign hit = |lane_eq;

   // R4: identical words always report a hit
   always_comb begin
      p_equal_words_r4: assert (src_a != src_b || hit)
         else $error("equal operands without a lane hit");
   end

   // R5: fully inverted operands never report a hit
   always_comb begin
      p_inverse_miss_r5: assert (src_a != ~src_b || !hit)
         else $error("complementary operands reported a hit");
   end

endmodule

// File: rtl/bytelane_logic_unit.sv
module bytelane_logic_unit #(
   parameter int  LANE_W = 8,
   parameter int  LANES  = 4,
   localparam int DATA_W = LANE_W * LANES,
   localparam int IMM_W  = DATA_W / 2
) (
   input  logic [DATA_W-1:0] opd_a,
   input  logic [DATA_W-1:0] opd_b,
   input  logic [IMM_W-1:0]  imm,
   input  logic [LANES-1:0]  lane_mask,
   input  logic [1:0]        op_sel,
   output logic [DATA_W-1:0] result,
   output logic              lane_hit
);
   import blu_pkg::*;

   if (LANE_W < 1 || LANES < 2) begin : g_bad_geom
      $error("bytelane_logic_unit: need LANE_W >= 1 and LANES >= 2");
   end
   if (DATA_W % 2 != 0) begin : g_odd_word
      $error("bytelane_logic_unit: word width must be even");
   end

   blu_op_e              op_e;
   logic [DATA_W-1:0]    and_res;
   logic [DATA_W-1:0]    or_res;
   logic [DATA_W-1:0]    mrg_res;

   assign op_e = blu_op_e'(op_sel);

   blu_upper_imm #(.DATA_W(DATA_W), .OR_MODE(1'b0)) u_and_hi (
      .src (opd_a),
      .imm (imm),
      .res (and_res)
   );

   blu_upper_imm #(.DATA_W(DATA_W), .OR_MODE(1'b1)) u_or_hi (
      .src (opd_a),
      .imm (imm),
      .res (or_res)
   );

   blu_lane_merge #(.LANE_W(LANE_W), .LANES(LANES)) u_merge (
      .src_a  (opd_a),
      .src_b  (opd_b),
      .pick_b (lane_mask),
      .merged (mrg_res)
   );

   blu_lane_cmp #(.LANE_W(LANE_W), .LANES(LANES)) u_cmp (
      .src_a (opd_a),
      .src_b (opd_b),
      .hit   (lane_hit)
   );

   always_comb begin
      unique case (op_e)
         OP_ANDHI: result = and_res;
         OP_ORHI:  result = or_res;
         OP_MERGE: result = mrg_res;
         default:  result = '0;
      endcase
   end

   // R6: compare operation drives a zero word
   always_comb begin
      p_zero_on_compare_r6: assert (op_e != OP_LANEEQ || result == '0)
         else $error("result not zero during lane compare");
   end

   // R3: merge with an all-clear mask returns the first operand
   always_comb begin
      p_merge_clear_mask_r3: assert (op_e != OP_MERGE || lane_mask != '0 || result == opd_a)
         else $error("merge with empty mask altered the operand");
   end

endmodule

// File: tb/test_bytelane_logic_unit.sv
`timescale 1ns/1ps
module test_bytelane_logic_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] opd_a = '0, opd_b = '0;
   logic [15:0] imm = '0;
   logic [3:0]  lane_mask = '0;
   logic [1:0]  op_sel = '0;
   logic [31:0] result;
   logic        lane_hit;
   logic [31:0] q_result;
   logic        q_hit;
   int          n_checks = 0;
   int          n_errors = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   bytelane_logic_unit i_bytelane_logic_unit (
      .opd_a     (opd_a),
      .opd_b     (opd_b),
      .imm       (imm),
      .lane_mask (lane_mask),
      .op_sel    (op_sel),
      .result    (result),
      .lane_hit  (lane_hit)
   );

   // registered wrapper stage
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_result <= '0;
         q_hit    <= 1'b0;
      end else begin
         q_result <= result;
         q_hit    <= lane_hit;
      end
   end

   typedef struct packed {
      logic [1:0]  op;
      logic [31:0] a;
      logic [31:0] b;
      logic [15:0] im;
      logic [3:0]  m;
      logic [31:0] exp_res;
      logic        exp_hit;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{2'b00, 32'h1234_5678, 32'hFFFF_FFFF, 16'h0F0F, 4'h0, 32'h0204_5678, 1'b0}, // R1
      '{2'b00, 32'hFFFF_FFFF, 32'h0000_0000, 16'h0000, 4'h0, 32'h0000_FFFF, 1'b0}, // R1
      '{2'b01, 32'h1234_5678, 32'h0000_0078, 16'hA0A0, 4'h0, 32'hB2B4_5678, 1'b1}, // R2
      '{2'b01, 32'h0000_0000, 32'h0000_0000, 16'hFFFF, 4'h0, 32'hFFFF_0000, 1'b1}, // R2
      '{2'b10, 32'h1122_3344, 32'hAABB_CCDD, 16'h0000, 4'h5, 32'h11BB_33DD, 1'b0}, // R3
      '{2'b10, 32'h1122_3344, 32'hAABB_CCDD, 16'h0000, 4'h0, 32'h1122_3344, 1'b0}, // R3
      '{2'b10, 32'h1122_3344, 32'hAABB_CCDD, 16'h0000, 4'hF, 32'hAABB_CCDD, 1'b0}, // R3
      '{2'b11, 32'hDEAD_BEEF, 32'h00AD_0000, 16'h0000, 4'h0, 32'h0000_0000, 1'b1}, // R4 R6
      '{2'b11, 32'h7700_0000, 32'h7711_1111, 16'h0000, 4'h0, 32'h0000_0000, 1'b1}, // R4 R6
      '{2'b11, 32'h0102_0304, 32'h1020_3040, 16'h0000, 4'h0, 32'h0000_0000, 1'b0}, // R5 R6
      '{2'b10, 32'hCAFE_0011, 32'hCAFE_0022, 16'hFFFF, 4'h2, 32'hCAFE_0011, 1'b1}  // R7
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_merge(input logic [31:0] a, input logic [31:0] b,
                                             input logic [3:0] m);
      logic [31:0] r;
      for (int k = 0; k < 4; k++) r[k*8 +: 8] = m[k] ? b[k*8 +: 8] : a[k*8 +: 8];
      return r;
   endfunction

   function automatic logic ref_hit(input logic [31:0] a, input logic [31:0] b);
      logic h = 1'b0;
      for (int k = 0; k < 4; k++) if (a[k*8 +: 8] == b[k*8 +: 8]) h = 1'b1;
      return h;
   endfunction

   task automatic apply(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] im, input logic [3:0] m);
      @(negedge clk);
      op_sel = o; opd_a = a; opd_b = b; imm = im; lane_mask = m;
      #1;
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] a;
      logic [31:0] b;
      // reset state of the registered stage (R8)
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R8 reset result", q_result, 32'h0);
      check("R8 reset hit", {31'b0, q_hit}, 32'h0);
      rst_n = 1'b1;

      // vector table
      for (int v = 0; v < NV; v++) begin
         apply(VECS[v].op, VECS[v].a, VECS[v].b, VECS[v].im, VECS[v].m);
         check($sformatf("R1/R2/R3/R6 vec %0d result", v), result, VECS[v].exp_res);
         check($sformatf("R4/R5/R7 vec %0d hit", v), {31'b0, lane_hit}, {31'b0, VECS[v].exp_hit});
         @(negedge clk);
         check($sformatf("R8 vec %0d registered", v), q_result, VECS[v].exp_res);
      end

      // R3: every mask value, one lane per bit
      for (int m = 0; m < 16; m++) begin
         apply(2'b10, 32'h0123_4567, 32'h89AB_CDEF, 16'h0, m[3:0]);
         check($sformatf("R3 mask %0d", m), result,
               ref_merge(32'h0123_4567, 32'h89AB_CDEF, m[3:0]));
      end

      // R4: exactly one matching lane, each position
      for (int k = 0; k < 4; k++) begin
         a = 32'h5A3C_96E1;
         b = ~a;
         b[k*8 +: 8] = a[k*8 +: 8];
         apply(2'b11, a, b, 16'h0, 4'h0);
         check($sformatf("R4 single lane %0d", k), {31'b0, lane_hit}, 32'h1);
      end

      // R5: all lanes differ by one bit each
      apply(2'b11, 32'h1111_1111, 32'h1010_1010, 16'h0, 4'h0);
      check("R5 all lanes differ", {31'b0, lane_hit}, 32'h0);

      // R7: flag constant across every op code, R6 result zero on compare
      a = 32'hABCD_0042;
      b = 32'h99CD_7742;
      for (int o = 0; o < 4; o++) begin
         apply(o[1:0], a, b, 16'h00FF, 4'h3);
         check($sformatf("R7 hit op %0d", o), {31'b0, lane_hit}, {31'b0, ref_hit(a, b)});
      end
      check("R6 compare result", result, 32'h0);

      // R1 R2: low half untouched under a changing immediate
      apply(2'b00, 32'h8001_BEEF, 32'h0, 16'hFFFF, 4'h0);
      check("R1 ones imm", result, 32'h8001_BEEF);
      apply(2'b01, 32'h8001_BEEF, 32'h0, 16'h0000, 4'h0);
      check("R2 zero imm", result, 32'h8001_BEEF);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule